// File: doc/BRIEF.md
# Voltage-Frequency Transition Sequencer

This block carries out operating-point changes that software requests. A request names a target PLL ratio and a target voltage code. The sequencer decides the order of work from the direction of the frequency change. When the frequency goes up, the voltage is raised first and the PLL is retargeted only after that. When the frequency goes down, the PLL is retargeted and relocked first and the voltage is lowered after it. The voltage code always moves one code at a time. Each step waits a programmable number of timebase ticks.

During the relock the core is held stalled and snooping is blocked. The PLL lock input decides when the relock ends. A stall timer bounds the relock in timebase ticks. If the timer expires, a sticky error flag is set and the core is released.

Requests are accepted on any cycle. A request that arrives while a transition is running is held and is started when the running one finishes. Only the newest held request is kept. A request for the operating point already in force completes with no stall.

Top module: `vf_seq`

## Requirements
- R1: After reset, `vid_out` equals parameter RST_VID, `ratio_out` equals RST_RATIO, and `core_stall`, `snoop_block`, `busy` and `stall_err` are all 0.
- R2: When the requested ratio is above the current ratio, `vid_out` reaches the requested code before `ratio_out` changes, and `vid_out` does not move while `core_stall` is 1.
- R3: When the requested ratio is below the current ratio, `ratio_out` changes and the relock ends before `vid_out` moves toward the requested code.
- R4: Every change of `vid_out` is exactly one code up or one code down.
- R5: Within a ramp, consecutive voltage steps are spaced by exactly `dwell_ticks`+1 cycles in which `tick` is 1.
- R6: `core_stall` and `snoop_block` are both 1 from the cycle in which `ratio_out` takes its new value until the relock ends, and both are 0 at all other times.
- R7: A request that arrives while a transition is in progress does not disturb that transition. It is run after that transition completes.
- R8: When several requests arrive during one transition, only the last one is run. Earlier held requests never reach `ratio_out`.
- R9: A request equal to the current ratio and voltage code completes within two cycles, with no stall and no snoop block.
- R10: A request with an unchanged ratio but a different voltage code ramps `vid_out` without stalling the core.
- R11: If the PLL lock input does not return within STALL_TMO ticks of relock, the stall ends and `stall_err` becomes 1. `stall_err` then stays 1 until reset.
- R12: `busy` is 1 from the cycle after a request is accepted until the transition completes. `busy` is 0 when the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase enable for dwell and stall counting |
| dwell_ticks | input | DWELL_W | Extra ticks to wait between voltage steps |
| req_valid | input | 1 | Operating-point request strobe |
| req_ratio | input | RATIO_W | Requested PLL ratio |
| req_vid | input | VID_W | Requested voltage code |
| pll_lock | input | 1 | PLL lock indication |
| vid_out | output | VID_W | Voltage code to the regulator |
| ratio_out | output | RATIO_W | Ratio to the PLL |
| core_stall | output | 1 | Core held during relock |
| snoop_block | output | 1 | Snoop traffic blocked during relock |
| busy | output | 1 | A request is held or a transition is running |
| stall_err | output | 1 | Sticky relock timeout flag |

## Verification
The bench builds the block with six-bit ratio and voltage fields, starting at ratio 10 and code 20. The stall limit is 20 ticks and the bench drives one tick every four cycles. These small values keep every ramp short. They also let a relock timeout fire within about eighty cycles. The bench changes `dwell_ticks` between 2 and 0, so step spacing is checked at more than one setting. A PLL model that drops lock for twelve cycles after a ratio change exercises the normal relock path. A switch that holds the model's lock low exercises the timeout path.

// File: rtl/vf_pkg.sv
package vf_pkg;
  parameter int RATIO_W = 6;
  parameter int VID_W   = 6;
  parameter int DWELL_W = 8;

  typedef struct packed {
    logic [RATIO_W-1:0] ratio;
    logic [VID_W-1:0]   vid;
  } op_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PRE    = 2'd1,
    ST_RELOCK = 2'd2,
    ST_POST   = 2'd3
  } seq_st_e;
endpackage

// File: rtl/vf_req_hold.sv
module vf_req_hold
  import vf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  op_t  req_op,
  input  logic take,
  output logic pend_valid,
  output op_t  pend_op
);
  logic valid_d;
  op_t  op_d;

  always_comb begin
    valid_d = pend_valid;
    op_d    = pend_op;
    if (req_valid) begin
      valid_d = 1'b1;
      op_d    = req_op;
    end else if (take) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_op    <= '0;
    end else begin
      pend_valid <= valid_d;
      pend_op    <= op_d;
    end
  end
endmodule

// File: rtl/vf_vid_ramp.sv
module vf_vid_ramp
  import vf_pkg::*;
#(
  parameter logic [VID_W-1:0] RST_VID = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               run,
  input  logic [DWELL_W-1:0] dwell,
  input  logic [VID_W-1:0]   target,
  output logic [VID_W-1:0]   vid,
  output logic               at_target
);
  logic [DWELL_W-1:0] cnt_q, cnt_d;
  logic [VID_W-1:0]   vid_d;

  assign at_target = (vid == target);

  always_comb begin
    cnt_d = cnt_q;
    vid_d = vid;
    if (!run || at_target) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_q == dwell) begin
        cnt_d = '0;
        vid_d = (target > vid) ? vid + 1'b1 : vid - 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      vid   <= RST_VID;
    end else begin
      cnt_q <= cnt_d;
      vid   <= vid_d;
    end
  end
endmodule

// File: rtl/vf_seq_ctrl.sv
module vf_seq_ctrl
  import vf_pkg::*;
#(
  parameter logic [RATIO_W-1:0] RST_RATIO = 10,
  parameter int                 STALL_TMO = 500,
  localparam int                TMO_W     = $clog2(STALL_TMO + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               pend_valid,
  input  op_t                pend_op,
  input  logic               pll_lock,
  input  logic [VID_W-1:0]   vid_now,
  input  logic               vid_done,
  output logic               take,
  output logic [RATIO_W-1:0] ratio_out,
  output logic [VID_W-1:0]   tgt_vid,
  output logic               ramp_run,
  output logic               relock,
  output logic               busy,
  output logic               stall_err
);
  seq_st_e             state_q, state_d;
  op_t                 tgt_q, tgt_d;
  logic [RATIO_W-1:0]  ratio_d;
  logic [TMO_W-1:0]    tmo_q, tmo_d;
  logic                lost_q, lost_d;
  logic                err_d;
  logic                tmo_hit;

  assign relock   = (state_q == ST_RELOCK);
  assign ramp_run = (state_q == ST_PRE) || (state_q == ST_POST);
  assign tgt_vid  = tgt_q.vid;
  assign busy     = pend_valid || (state_q != ST_IDLE);
  assign tmo_hit  = relock && tick && (tmo_q == TMO_W'(STALL_TMO - 1));

  always_comb begin
    state_d = state_q;
    tgt_d   = tgt_q;
    take    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (pend_valid) begin
          take  = 1'b1;
          tgt_d = pend_op;
          if (pend_op.ratio > ratio_out)      state_d = ST_PRE;
          else if (pend_op.ratio < ratio_out) state_d = ST_RELOCK;
          else if (pend_op.vid != vid_now)    state_d = ST_POST;
        end
      end
      ST_PRE: begin
        if (vid_done) state_d = ST_RELOCK;
      end
      ST_RELOCK: begin
        if ((lost_q && pll_lock) || tmo_hit)
          state_d = (vid_now != tgt_q.vid) ? ST_POST : ST_IDLE;
      end
      ST_POST: begin
        if (vid_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    ratio_d = ratio_out;
    if (state_d == ST_RELOCK && state_q != ST_RELOCK) ratio_d = tgt_d.ratio;
    tmo_d  = '0;
    lost_d = 1'b0;
    if (relock) begin
      tmo_d  = tick ? tmo_q + 1'b1 : tmo_q;
      lost_d = lost_q || !pll_lock;
    end
    err_d = stall_err || tmo_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      tgt_q     <= '0;
      ratio_out <= RST_RATIO;
      tmo_q     <= '0;
      lost_q    <= 1'b0;
      stall_err <= 1'b0;
    end else begin
      state_q   <= state_d;
      tgt_q     <= tgt_d;
      ratio_out <= ratio_d;
      tmo_q     <= tmo_d;
      lost_q    <= lost_d;
      stall_err <= err_d;
    end
  end
endmodule

// File: rtl/vf_seq.sv
module vf_seq
  import vf_pkg::*;
#(
  parameter logic [RATIO_W-1:0] RST_RATIO = 10,
  parameter logic [VID_W-1:0]   RST_VID   = 20,
  parameter int                 STALL_TMO = 500
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [DWELL_W-1:0] dwell_ticks,
  input  logic               req_valid,
  input  logic [RATIO_W-1:0] req_ratio,
  input  logic [VID_W-1:0]   req_vid,
  input  logic               pll_lock,
  output logic [VID_W-1:0]   vid_out,
  output logic [RATIO_W-1:0] ratio_out,
  output logic               core_stall,
  output logic               snoop_block,
  output logic               busy,
  output logic               stall_err
);
  op_t              req_op, pend_op;
  logic             pend_valid, take, ramp_run, relock, vid_done;
  logic [VID_W-1:0] tgt_vid;

  assign req_op.ratio = req_ratio;
  assign req_op.vid   = req_vid;
  assign core_stall   = relock;
  assign snoop_block  = relock;

  vf_req_hold u_hold (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .take(take), .pend_valid(pend_valid), .pend_op(pend_op)
  );

  vf_vid_ramp #(.RST_VID(RST_VID)) u_ramp (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(ramp_run),
    .dwell(dwell_ticks), .target(tgt_vid), .vid(vid_out), .at_target(vid_done)
  );

  vf_seq_ctrl #(.RST_RATIO(RST_RATIO), .STALL_TMO(STALL_TMO)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pend_valid(pend_valid),
    .pend_op(pend_op), .pll_lock(pll_lock), .vid_now(vid_out),
    .vid_done(vid_done), .take(take), .ratio_out(ratio_out),
    .tgt_vid(tgt_vid), .ramp_run(ramp_run), .relock(relock),
    .busy(busy), .stall_err(stall_err)
  );
endmodule

// File: rtl/vf_seq_chk.sv
module vf_seq_chk
  import vf_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [VID_W-1:0]   vid_out,
  input logic [RATIO_W-1:0] ratio_out,
  input logic               core_stall,
  input logic               busy,
  input logic               stall_err
);
  // R4
  vid_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_out == $past(vid_out)) || (vid_out == $past(vid_out) + 1'b1) ||
    (vid_out == $past(vid_out) - 1'b1));

  // R6
  ratio_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_out != $past(ratio_out)) |-> core_stall);

  // R2
  vid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_stall && $past(core_stall)) |-> $stable(vid_out));

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_err |=> stall_err);

  // R12
  idle_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !core_stall);
endmodule

bind vf_seq vf_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .vid_out(vid_out), .ratio_out(ratio_out),
  .core_stall(core_stall), .busy(busy), .stall_err(stall_err)
);

// File: tb/vf_seq_tb.sv
module vf_seq_tb;
  import vf_pkg::*;

  localparam int TMO = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [DWELL_W-1:0] dwell_ticks = '0;
  logic req_valid = 1'b0;
  logic [RATIO_W-1:0] req_ratio = '0;
  logic [VID_W-1:0] req_vid = '0;
  logic pll_lock;
  logic pll_dead = 1'b0;
  logic [VID_W-1:0] vid_out;
  logic [RATIO_W-1:0] ratio_out;
  logic core_stall, snoop_block, busy, stall_err;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  vf_seq #(.RST_RATIO(6'd10), .RST_VID(6'd20), .STALL_TMO(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .dwell_ticks(dwell_ticks),
    .req_valid(req_valid), .req_ratio(req_ratio), .req_vid(req_vid),
    .pll_lock(pll_lock), .vid_out(vid_out), .ratio_out(ratio_out),
    .core_stall(core_stall), .snoop_block(snoop_block), .busy(busy),
    .stall_err(stall_err)
  );

  // PLL model: lock drops for 12 cycles after each ratio change
  logic [RATIO_W-1:0] pll_ratio;
  int lk_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pll_ratio <= 6'd10;
      lk_cnt    <= 0;
    end else if (ratio_out != pll_ratio) begin
      pll_ratio <= ratio_out;
      lk_cnt    <= 12;
    end else if (lk_cnt != 0) begin
      lk_cnt <= lk_cnt - 1;
    end
  end
  assign pll_lock = (lk_cnt == 0) && !pll_dead;

  initial begin
    int tc;
    tc = 0;
    forever begin
      @(posedge clk);
      #1 tick = (tc == 3);
      tc = (tc + 1) % 4;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int r, input int v);
    @(posedge clk);
    #1;
    req_valid = 1'b1;
    req_ratio = RATIO_W'(r);
    req_vid   = VID_W'(v);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  // watch a transition until idle; dir: 1 up, -1 down, 0 same ratio
  int st_cycles, gap_bad, order_bad, stall_bad, step_bad, seen_ratio_bad, cyc;
  task automatic watch(input int dir, input int er, input int ev, input int bad_ratio);
    int prev_v, prev_r, gap;
    bit have_step, stall_was;
    prev_v = int'(vid_out); prev_r = int'(ratio_out);
    gap = 0; have_step = 0; stall_was = 0;
    st_cycles = 0; gap_bad = 0; order_bad = 0; stall_bad = 0; step_bad = 0;
    seen_ratio_bad = 0; cyc = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      cyc++;
      if (core_stall) st_cycles++;
      if (snoop_block != core_stall) stall_bad++;
      if (int'(ratio_out) == bad_ratio) seen_ratio_bad++;
      if (int'(ratio_out) != prev_r && !core_stall) stall_bad++;
      if (int'(vid_out) != prev_v) begin
        if (int'(vid_out) != prev_v + 1 && int'(vid_out) != prev_v - 1) step_bad++;
        if (have_step && gap != int'(dwell_ticks) + 1) gap_bad++;
        if (dir < 0 && (core_stall || int'(ratio_out) != er)) order_bad++;
        have_step = 1;
        gap = 0;
      end
      if (dir > 0 && int'(ratio_out) != prev_r && int'(vid_out) != ev) order_bad++;
      if (tick) gap++;
      prev_v = int'(vid_out);
      prev_r = int'(ratio_out);
      if (!busy) break;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(vid_out == 6'd20, "R1 vid", int'(vid_out), 20);
    check(ratio_out == 6'd10, "R1 ratio", int'(ratio_out), 10);
    check(!core_stall && !snoop_block && !busy && !stall_err, "R1 flags",
          int'({core_stall, snoop_block, busy, stall_err}), 0);
  endtask

  task automatic t_up();
    dwell_ticks = 8'd2;
    send(14, 24);
    check(busy, "R12 busy after request", int'(busy), 1);
    watch(1, 14, 24, -1);
    check(order_bad == 0, "R2 order", order_bad, 0);
    check(vid_out == 6'd24 && ratio_out == 6'd14, "R2 final",
          int'({ratio_out, vid_out}), (14 << 6) | 24);
    check(gap_bad == 0, "R5 dwell 2", gap_bad, 0);
    check(step_bad == 0, "R4 step", step_bad, 0);
    check(stall_bad == 0 && st_cycles > 12, "R6 stall", st_cycles, 13);
    check(!busy, "R12 idle", int'(busy), 0);
  endtask

  task automatic t_down();
    dwell_ticks = 8'd0;
    send(8, 18);
    watch(-1, 8, 18, -1);
    check(order_bad == 0, "R3 order", order_bad, 0);
    check(vid_out == 6'd18 && ratio_out == 6'd8, "R3 final",
          int'({ratio_out, vid_out}), (8 << 6) | 18);
    check(gap_bad == 0, "R5 dwell 0", gap_bad, 0);
    check(stall_bad == 0 && st_cycles > 0, "R6 stall down", st_cycles, 1);
  endtask

  task automatic t_equal();
    send(8, 18);
    watch(0, 8, 18, -1);
    check(st_cycles == 0, "R9 no stall", st_cycles, 0);
    check(cyc <= 2, "R9 quick", cyc, 2);
    check(vid_out == 6'd18 && ratio_out == 6'd8, "R9 unchanged",
          int'({ratio_out, vid_out}), (8 << 6) | 18);
  endtask

  task automatic t_vid_only();
    dwell_ticks = 8'd1;
    send(8, 21);
    watch(0, 8, 21, -1);
    check(st_cycles == 0, "R10 no stall", st_cycles, 0);
    check(vid_out == 6'd21 && ratio_out == 6'd8, "R10 final",
          int'({ratio_out, vid_out}), (8 << 6) | 21);
  endtask

  task automatic t_defer();
    dwell_ticks = 8'd2;
    send(12, 23);
    repeat (5) @(posedge clk);
    send(6, 16);
    repeat (3) @(posedge clk);
    send(9, 19);
    // first transition must still finish at its own target
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (ratio_out == 6'd12) break;
    end
    check(ratio_out == 6'd12 && vid_out == 6'd23, "R7 first completes",
          int'({ratio_out, vid_out}), (12 << 6) | 23);
    watch(-1, 9, 19, 6);
    check(vid_out == 6'd19 && ratio_out == 6'd9, "R8 latest run",
          int'({ratio_out, vid_out}), (9 << 6) | 19);
    check(seen_ratio_bad == 0, "R8 older dropped", seen_ratio_bad, 0);
    check(order_bad == 0, "R7 deferred order", order_bad, 0);
  endtask

  task automatic t_timeout();
    pll_dead = 1'b1;
    send(11, 19);
    watch(1, 11, 19, -1);
    check(st_cycles >= TMO * 4 - 4 && st_cycles <= TMO * 4 + 4, "R11 stall bound",
          st_cycles, TMO * 4);
    check(stall_err, "R11 err set", int'(stall_err), 1);
    check(ratio_out == 6'd11, "R11 ratio", int'(ratio_out), 11);
    pll_dead = 1'b0;
    send(11, 20);
    watch(0, 11, 20, -1);
    check(stall_err, "R11 sticky", int'(stall_err), 1);
    check(vid_out == 6'd20, "R10 after err", int'(vid_out), 20);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_up();
        t_down();
        t_equal();
        t_vid_only();
        t_defer();
        t_timeout();
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule